// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block keeps the modem control byte of a 16550-style serial port and builds the matching modem status byte. Software writes the control byte through a one-cycle write strobe. It reads the status byte through a read strobe. The read returns the whole byte in the same cycle and clears the change flags at the next clock edge.

When the loopback bit of the control byte is set, the four modem output lines are fed back as the four status lines. When loopback is clear, the status lines show a fixed idle pattern: carrier and data-set-ready are present, and clear-to-send and ring are absent. Every control write compares the old status lines with the new ones. Any change is recorded in sticky change flags. A modem interrupt request goes to the interrupt logic whenever a change flag is set and the external modem interrupt enable is high.

Top module: `mdm_line_ctrl`

## Requirements
- R1: A control write stores bits 4:0 of the write data at the next clock edge. The control byte reads back with bits 7:5 at zero. The control bits are: bit 0 terminal-ready output, bit 1 request-to-send output, bit 2 auxiliary output 1, bit 3 auxiliary output 2, bit 4 loopback.
- R2: After a synchronous reset, the control byte is 0x00, the status byte is 0xA0 and the interrupt request is low.
- R3: With loopback set, the status line bits are set from the control bits: bit 4 (clear-to-send) from control bit 1, bit 5 (data-set-ready) from control bit 0, bit 6 (ring) from control bit 2, and bit 7 (carrier) from control bit 3.
- R4: With loopback clear, status bits 7:4 equal 4'b1010: carrier and data-set-ready are 1, ring and clear-to-send are 0.
- R5: At a control write, any difference between the old and new values of clear-to-send, data-set-ready or carrier sets status bit 0, 1 or 3 respectively.
- R6: Status bit 2 is set only when a control write moves the ring line from 1 to 0. A move from 0 to 1 leaves it unchanged.
- R7: The change flags (bits 3:0) are sticky. A control write replaces bits 7:4 and keeps every flag already set.
- R8: A status read returns the full current byte in the same cycle. At the next edge it clears bits 3:0 and leaves bits 7:4 unchanged.
- R9: If a control write and a status read fall in the same cycle, flags detected by that write are set after the edge. Flags that were set earlier are cleared.
- R10: The modem interrupt request is high exactly when at least one of bits 3:0 of the status byte is set and the modem interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | 8 | Control byte write data |
| ctl_rd_data | output | 8 | Current control byte |
| sts_rd_en | input | 1 | Status read strobe; clears change flags at the next edge |
| sts_rd_data | output | 8 | Current status byte |
| msi_enable | input | 1 | Modem interrupt enable |
| msi_req | output | 1 | Modem interrupt request |

## Verification
Directed sequences first set every loopback pattern one line at a time. This shows whether each control bit is routed to its own status bit or crossed with a neighbour. A ring line driven 0 to 1 and then 1 to 0 separates a trailing-edge detector from a plain toggle detector. Entering and leaving loopback shows whether the forced idle pattern is applied. A write and a read in the same cycle, with an old flag still pending, shows whether new flags win over the clear. A fixed-seed random mix of writes, reads and enable changes is then compared every cycle against a bench model. This finds flags that are lost or left standing after long runs of writes without reads.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int REG_W = 8;
    localparam int CTL_W = 5;
    localparam int LN_W  = 4;
    localparam int DL_W  = 4;
    localparam int PAD_W = REG_W - CTL_W;

    // control byte bits 4:0
    typedef struct packed {
        logic loop_en;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } ctl_t;

    // status bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    // status bits 3:0
    typedef struct packed {
        logic d_dcd;
        logic ri_trail;
        logic d_dsr;
        logic d_cts;
    } delta_t;

    typedef struct packed {
        lines_t ln;
        delta_t dl;
    } status_t;

    localparam lines_t IDLE_LINES = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};

    function automatic lines_t map_lines(input ctl_t c);
        lines_t l;
        if (c.loop_en) begin
            l.cts = c.rts;
            l.dsr = c.dtr;
            l.ri  = c.aux1;
            l.dcd = c.aux2;
        end else begin
            l = IDLE_LINES;
        end
        return l;
    endfunction

    function automatic delta_t detect_changes(input lines_t prev, input lines_t nxt);
        delta_t d;
        d.d_cts    = prev.cts ^ nxt.cts;
        d.d_dsr    = prev.dsr ^ nxt.dsr;
        d.d_dcd    = prev.dcd ^ nxt.dcd;
        d.ri_trail = prev.ri & ~nxt.ri;
        return d;
    endfunction

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_t             ctl_next,
    output ctl_t             ctl_q
);

    always_comb begin
        ctl_next = wr_en ? ctl_t'(wr_data[CTL_W-1:0]) : ctl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_next;
        end
    end

endmodule

// File: rtl/mdm_line_map.sv
module mdm_line_map
    import mdm_pkg::*;
(
    input  ctl_t   ctl_i,
    output lines_t lines_o
);

    always_comb begin
        lines_o = map_lines(ctl_i);
    end

endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
    import mdm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    upd_en,
    input  lines_t  new_lines,
    input  logic    clr_en,
    output status_t sts_q
);

    delta_t found;
    delta_t kept;

    always_comb begin
        found = upd_en ? detect_changes(sts_q.ln, new_lines) : '0;
        kept  = clr_en ? '0 : sts_q.dl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q.ln <= IDLE_LINES;
            sts_q.dl <= '0;
        end else begin
            if (upd_en) begin
                sts_q.ln <= new_lines;
            end
            sts_q.dl <= kept | found;
        end
    end

endmodule

// File: rtl/mdm_line_ctrl.sv
module mdm_line_ctrl
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr_en,
    input  logic [REG_W-1:0] ctl_wr_data,
    output logic [REG_W-1:0] ctl_rd_data,
    input  logic             sts_rd_en,
    output logic [REG_W-1:0] sts_rd_data,
    input  logic             msi_enable,
    output logic             msi_req
);

    ctl_t    ctl_next;
    ctl_t    ctl_q;
    lines_t  next_lines;
    status_t sts_q;

    mdm_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .ctl_next (ctl_next),
        .ctl_q    (ctl_q)
    );

    mdm_line_map u_map (
        .ctl_i   (ctl_next),
        .lines_o (next_lines)
    );

    mdm_status_reg u_sts (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (ctl_wr_en),
        .new_lines (next_lines),
        .clr_en    (sts_rd_en),
        .sts_q     (sts_q)
    );

    assign ctl_rd_data = {{PAD_W{1'b0}}, ctl_q};
    assign sts_rd_data = sts_q;
    assign msi_req     = msi_enable & (|sts_q.dl);

endmodule

// File: rtl/mdm_line_ctrl_chk.sv
module mdm_line_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr_en,
    input logic [7:0] ctl_rd_data,
    input logic       sts_rd_en,
    input logic [7:0] sts_rd_data,
    input logic       msi_enable,
    input logic       msi_req
);

    AST_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl_rd_data[7:5] == 3'b000); // R1

    AST_LOOP_ROUTE: assert property (@(posedge clk) disable iff (rst)
        ctl_rd_data[4] |-> sts_rd_data[7:4] ==
            {ctl_rd_data[3], ctl_rd_data[2], ctl_rd_data[0], ctl_rd_data[1]}); // R3

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_data[4] |-> sts_rd_data[7:4] == 4'b1010); // R4

    AST_RI_TRAIL_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_rd_data[2]) |-> ($past(sts_rd_data[6]) && !sts_rd_data[6])); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !sts_rd_en |=> ((sts_rd_data[3:0] & $past(sts_rd_data[3:0])) == $past(sts_rd_data[3:0]))); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sts_rd_en && !ctl_wr_en) |=> (sts_rd_data[3:0] == 4'h0 && $stable(sts_rd_data[7:4]))); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        msi_req |-> (msi_enable && sts_rd_data[3:0] != 4'h0)); // R10

endmodule

bind mdm_line_ctrl mdm_line_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_rd_data (ctl_rd_data),
    .sts_rd_en   (sts_rd_en),
    .sts_rd_data (sts_rd_data),
    .msi_enable  (msi_enable),
    .msi_req     (msi_req)
);

// File: tb/mdm_line_ctrl_tb_top.sv
module mdm_line_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = 8'h00;
    logic [7:0] ctl_rd_data;
    logic       sts_rd_en = 1'b0;
    logic [7:0] sts_rd_data;
    logic       msi_enable = 1'b0;
    logic       msi_req;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    logic [7:0] m_ctl;
    logic [7:0] m_sts;

    always #2 clk = ~clk;

    mdm_line_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .ctl_rd_data (ctl_rd_data),
        .sts_rd_en   (sts_rd_en),
        .sts_rd_data (sts_rd_data),
        .msi_enable  (msi_enable),
        .msi_req     (msi_req)
    );

    // status bits 7:4 (DCD,RI,DSR,CTS) expected from a control byte
    function automatic logic [3:0] exp_lines(input logic [7:0] c);
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return 4'b1010;
    endfunction

    function automatic logic [7:0] exp_next(input logic [7:0] sts, input logic wr,
                                            input logic [7:0] wd, input logic rd);
        logic [3:0] o, n, d;
        o = sts[7:4];
        n = wr ? exp_lines(wd & 8'h1F) : o;
        d = 4'h0;
        if (wr) begin
            d[0] = o[0] ^ n[0];
            d[1] = o[1] ^ n[1];
            d[3] = o[3] ^ n[3];
            d[2] = o[2] & ~n[2];
        end
        return {n, (rd ? 4'h0 : sts[3:0]) | d};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one cycle; check read data before the edge and outputs after it
    task automatic step(input logic wr, input logic [7:0] wd, input logic rd, input logic en);
        ctl_wr_en   = wr;
        ctl_wr_data = wd;
        sts_rd_en   = rd;
        msi_enable  = en;
        #1;
        if (rd) chk("R8 read value", sts_rd_data, m_sts);
        @(posedge clk);
        m_sts = exp_next(m_sts, wr, wd, rd);
        if (wr) m_ctl = wd & 8'h1F;
        @(negedge clk);
        chk("R1 control", ctl_rd_data, m_ctl);
        chk("R7 status", sts_rd_data, m_sts);
        chk("R10 irq", {7'd0, msi_req}, {7'd0, en & (|m_sts[3:0])});
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_ctl = 8'h00;
        m_sts = 8'hA0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset control", ctl_rd_data, 8'h00);
        chk("R2 reset status", sts_rd_data, 8'hA0);
        chk("R2 reset irq", {7'd0, msi_req}, 8'h00);

        // upper bits dropped
        step(1'b1, 8'hE0, 1'b0, 1'b1);
        chk("R1 upper bits", ctl_rd_data, 8'h00);
        // enter loopback with all outputs low: DCD,DSR fall
        step(1'b1, 8'h10, 1'b0, 1'b1);
        chk("R5 enter loop", sts_rd_data, 8'h0A);
        chk("R10 irq on", {7'd0, msi_req}, 8'h01);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R8 cleared", sts_rd_data, 8'h00);
        // each output alone
        step(1'b1, 8'h11, 1'b1, 1'b0);
        chk("R3 dtr->dsr", sts_rd_data, 8'h22);
        step(1'b1, 8'h12, 1'b1, 1'b0);
        chk("R3 rts->cts", sts_rd_data, 8'h13);
        step(1'b1, 8'h14, 1'b1, 1'b0);
        chk("R3 out1->ri", sts_rd_data, 8'h41);
        step(1'b1, 8'h18, 1'b1, 1'b0);
        chk("R6 ri fall", sts_rd_data, 8'h8C);
        step(1'b1, 8'h1C, 1'b1, 1'b0);
        chk("R6 ri rise no flag", sts_rd_data, 8'hC0);
        // sticky over two writes
        step(1'b1, 8'h1E, 1'b0, 1'b0);
        step(1'b1, 8'h1F, 1'b0, 1'b0);
        chk("R7 sticky", sts_rd_data, 8'hF3);
        // write with read same cycle, old flags pending
        step(1'b1, 8'h1B, 1'b1, 1'b1);
        chk("R9 new wins", sts_rd_data, 8'hB4);
        // leave loopback
        step(1'b1, 8'h00, 1'b1, 1'b1);
        chk("R4 idle lines", sts_rd_data, 8'hA1);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R4 idle quiet", sts_rd_data, 8'hA0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[15:8], r[2] & r[3], r[4]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule